// File: doc/BRIEF.md
# Keyed Pulse Delay Scheduler

This block produces the slot-by-slot timing for a transmitted-reference impulse transmitter. One clock cycle is one time slot. After a start request the block runs one packet made of a fixed number of frames, each frame a fixed number of slots long. Each frame carries two single-cycle strobes: a reference strobe, and after it a data strobe. A per-frame random offset places the reference strobe inside the frame. The spacing between the two strobes comes from a secret key.

The key is cut into equal segments, and the frames of a packet into the same number of consecutive groups. The segment with index g sets the reference-to-data spacing for every frame of group g. A receiver that holds the key can therefore line up each data pulse against its reference without knowing the random offsets. A polarity line goes with the strobes. It is positive for the reference pulse and follows the frame's payload bit for the data pulse. A single-cycle done flag closes the packet.

Top module: `keyed_pulse_sched`

## Requirements
- R1: While reset is held, and in every cycle of idle after it, refStb, dataStb, dataPol and done are all low.
- R2: When start is high in an idle cycle, keyIn and payloadIn are captured at that clock edge, and the next cycle is slot 0 of frame 0. Later changes to keyIn or payloadIn do not affect the packet in progress.
- R3: The value on rndIn at the edge that begins a frame is the frame's offset. refStb is high for one cycle, in the slot whose index equals that offset.
- R4: dataStb is high for one cycle, in slot offset+d+1 of the frame. d is key segment g = keyIn[4g+3:4g], and it applies to frames 4g through 4g+3 (defaults: 16-bit key, 4 segments, 16 frames, 64 slots per frame).
- R5: Each frame has exactly one reference strobe and one data strobe, and the two are never high together.
- R6: dataPol is 1 while refStb is high. While dataStb is high in frame f, dataPol equals payloadIn bit f. In every other cycle dataPol is 0.
- R7: rndIn has no effect in any cycle other than the one before a frame begins.
- R8: A packet lasts 16 frames of 64 slots. done is high for exactly the one cycle after slot 63 of frame 15, and no strobe is high in that cycle.
- R9: A start pulse during a running packet is ignored.
- R10: A start in the done cycle begins a new packet at once, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Packet start request |
| keyIn | input | 16 | Secret delay key |
| payloadIn | input | 16 | One payload bit per frame |
| rndIn | input | 3 | Random offset source |
| refStb | output | 1 | Reference pulse strobe |
| dataStb | output | 1 | Data pulse strobe |
| dataPol | output | 1 | Pulse polarity |
| done | output | 1 | Packet finished pulse |

## Verification
The hardest case to reach is the widest frame: the largest offset, 7, combined with the longest delay segment, 15, so that the data pulse lands deep in the frame. The other hard case is a start that lands exactly in the done cycle. The bench sweeps sixteen back-to-back packets. Their key segments and per-frame offsets are arranged so that every delay value meets every offset across the run. Each packet after the first is started in the previous packet's done cycle. Between frame boundaries rndIn carries misleading values, and the key and payload inputs are scrambled right after capture. A stray start is pulsed in the middle of every packet.

// File: rtl/keyed_pulse_pkg.sv
package keyed_pulse_pkg;

  typedef enum logic [2:0] {
    IDLE,
    FRAME_WAIT,
    REF,
    GAP,
    DATA,
    FRAME_END
  } sched_state_t;

  typedef struct packed {
    logic load;   // capture inputs, restart counters
    logic step;   // advance one slot
  } sched_ctl_t;

endpackage

// File: rtl/kps_datapath.sv
module kps_datapath
  import keyed_pulse_pkg::*;
#(
  parameter int KEY_W  = 16,
  parameter int SEGS   = 4,
  parameter int FRAMES = 16,
  parameter int SLOTS  = 64,
  parameter int OFF_W  = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  sched_ctl_t                    ctl,
  input  logic [KEY_W-1:0]              keyIn,
  input  logic [FRAMES-1:0]             payloadIn,
  input  logic [OFF_W-1:0]              rndIn,
  output logic                          frameEnd,
  output logic                          lastFrame,
  output logic [$clog2(SLOTS)-1:0]      nSlot,
  output logic [OFF_W-1:0]              nOff,
  output logic [KEY_W/SEGS-1:0]         nDly,
  output logic                          curBit
);
  localparam int SEG_W  = KEY_W / SEGS;
  localparam int FPG    = FRAMES / SEGS;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int FRM_W  = $clog2(FRAMES);
  localparam int GRP_W  = (SEGS > 1) ? $clog2(SEGS) : 1;

  logic [KEY_W-1:0]  keyR, nKey;
  logic [FRAMES-1:0] payR;
  logic [SLOT_W-1:0] slotR;
  logic [FRM_W-1:0]  frameR, nFrame;
  logic [OFF_W-1:0]  offR;
  logic [GRP_W-1:0]  grpIdx;
  logic [SEG_W-1:0]  segArr [SEGS];

  assign frameEnd  = (slotR == SLOT_W'(SLOTS - 1));
  assign lastFrame = (frameR == FRM_W'(FRAMES - 1));
  assign curBit    = payR[frameR];

  always_comb begin
    nKey   = keyR;
    nSlot  = slotR;
    nFrame = frameR;
    nOff   = offR;
    if (ctl.load) begin
      nKey   = keyIn;
      nSlot  = '0;
      nFrame = '0;
      nOff   = rndIn;
    end else if (ctl.step) begin
      if (frameEnd) begin
        nSlot  = '0;
        nFrame = frameR + FRM_W'(1);
        nOff   = rndIn;
      end else begin
        nSlot  = slotR + SLOT_W'(1);
      end
    end
  end

  for (genvar g = 0; g < SEGS; g++) begin : gSeg
    assign segArr[g] = nKey[g*SEG_W +: SEG_W];
  end

  assign grpIdx = GRP_W'(nFrame / FRM_W'(FPG));
  assign nDly   = segArr[grpIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyR   <= '0;
      payR   <= '0;
      slotR  <= '0;
      frameR <= '0;
      offR   <= '0;
    end else begin
      keyR   <= nKey;
      if (ctl.load) payR <= payloadIn;
      slotR  <= nSlot;
      frameR <= nFrame;
      offR   <= nOff;
    end
  end
endmodule

// File: rtl/kps_control.sv
module kps_control
  import keyed_pulse_pkg::*;
#(
  parameter int SLOT_W = 6,
  parameter int OFF_W  = 3,
  parameter int SEG_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              frameEnd,
  input  logic              lastFrame,
  input  logic [SLOT_W-1:0] nSlot,
  input  logic [OFF_W-1:0]  nOff,
  input  logic [SEG_W-1:0]  nDly,
  input  logic              curBit,
  output sched_ctl_t        ctl,
  output logic              refStb,
  output logic              dataStb,
  output logic              dataPol,
  output logic              done
);
  localparam int CW = SLOT_W + 1;

  sched_state_t state, nState;
  logic running, finish;
  logic [CW-1:0] slotW, refAt, dataAt;

  assign running  = (state != IDLE);
  assign finish   = running && frameEnd && lastFrame;
  assign ctl.load = !running && start;
  assign ctl.step = running && !finish;

  assign slotW  = CW'(nSlot);
  assign refAt  = CW'(nOff);
  assign dataAt = refAt + CW'(nDly) + CW'(1);

  always_comb begin
    nState = state;
    if (ctl.load || ctl.step) begin
      if (slotW < refAt)       nState = FRAME_WAIT;
      else if (slotW == refAt) nState = REF;
      else if (slotW < dataAt) nState = GAP;
      else if (slotW == dataAt) nState = DATA;
      else                     nState = FRAME_END;
    end else if (finish) begin
      nState = IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= IDLE;
      done  <= 1'b0;
    end else begin
      state <= nState;
      done  <= finish;
    end
  end

  assign refStb  = (state == REF);
  assign dataStb = (state == DATA);
  assign dataPol = refStb | (dataStb & curBit);
endmodule

// File: rtl/keyed_pulse_sched.sv
module keyed_pulse_sched
  import keyed_pulse_pkg::*;
#(
  parameter int KEY_W  = 16,
  parameter int SEGS   = 4,
  parameter int FRAMES = 16,
  parameter int SLOTS  = 64,
  parameter int OFF_W  = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [KEY_W-1:0]     keyIn,
  input  logic [FRAMES-1:0]    payloadIn,
  input  logic [OFF_W-1:0]     rndIn,
  output logic                 refStb,
  output logic                 dataStb,
  output logic                 dataPol,
  output logic                 done
);
  localparam int SEG_W  = KEY_W / SEGS;
  localparam int SLOT_W = $clog2(SLOTS);

  initial begin
    assert ((1 << OFF_W) - 1 + (1 << SEG_W) + 1 <= SLOTS)
      else $error("offset plus longest delay does not fit in a frame");
  end

  sched_ctl_t        ctl;
  logic              frameEnd, lastFrame, curBit;
  logic [SLOT_W-1:0] nSlot;
  logic [OFF_W-1:0]  nOff;
  logic [SEG_W-1:0]  nDly;

  kps_datapath #(
    .KEY_W(KEY_W), .SEGS(SEGS), .FRAMES(FRAMES), .SLOTS(SLOTS), .OFF_W(OFF_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .keyIn(keyIn), .payloadIn(payloadIn),
    .rndIn(rndIn), .frameEnd(frameEnd), .lastFrame(lastFrame), .nSlot(nSlot),
    .nOff(nOff), .nDly(nDly), .curBit(curBit)
  );

  kps_control #(
    .SLOT_W(SLOT_W), .OFF_W(OFF_W), .SEG_W(SEG_W)
  ) uCtl (
    .clk(clk), .rstN(rstN), .start(start), .frameEnd(frameEnd),
    .lastFrame(lastFrame), .nSlot(nSlot), .nOff(nOff), .nDly(nDly),
    .curBit(curBit), .ctl(ctl), .refStb(refStb), .dataStb(dataStb),
    .dataPol(dataPol), .done(done)
  );
endmodule

// File: rtl/keyed_pulse_sched_chk.sv
module keyed_pulse_sched_chk #(
  parameter int MAX_GAP = 16
) (
  input logic clk,
  input logic rstN,
  input logic refStb,
  input logic dataStb,
  input logic dataPol,
  input logic done
);
  logic [7:0] sinceRef;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRef <= 8'hFF;
    else if (refStb)           sinceRef <= 8'h00;
    else if (sinceRef != 8'hFF) sinceRef <= sinceRef + 8'd1;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(refStb && dataStb)); // R5
  AST_REF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    refStb |=> !refStb); // R3
  AST_DATA_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    dataStb |=> !dataStb); // R4
  AST_GAP_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    dataStb |-> (sinceRef < 8'(MAX_GAP))); // R4
  AST_REF_POSITIVE: assert property (@(posedge clk) disable iff (!rstN)
    refStb |-> dataPol); // R6
  AST_POL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(refStb || dataStb) |-> !dataPol); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !(refStb || dataStb)); // R8
endmodule

bind keyed_pulse_sched keyed_pulse_sched_chk #(
  .MAX_GAP(1 << (KEY_W / SEGS))
) uChk (
  .clk(clk), .rstN(rstN), .refStb(refStb), .dataStb(dataStb),
  .dataPol(dataPol), .done(done)
);

// File: tb/sim_keyed_pulse_sched.sv
`timescale 1ns/1ps
module sim_keyed_pulse_sched;
  localparam int NPKT   = 16;
  localparam int FRAMES = 16;
  localparam int SLOTS  = 64;
  localparam int PKT_CYC = FRAMES * SLOTS;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] keyIn = '0;
  logic [15:0] payloadIn = '0;
  logic [2:0]  rndIn = '0;
  logic        refStb, dataStb, dataPol, done;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  keyed_pulse_sched u0 (
    .clk(clk), .rstN(rstN), .start(start), .keyIn(keyIn),
    .payloadIn(payloadIn), .rndIn(rndIn), .refStb(refStb),
    .dataStb(dataStb), .dataPol(dataPol), .done(done)
  );

  function automatic int offOf(int p, int f);
    return (p + 3 * f) % 8;
  endfunction

  function automatic int segOf(int p, int g);
    return (p + 5 * g) % 16;
  endfunction

  function automatic logic [15:0] keyOf(int p);
    logic [15:0] k = '0;
    for (int g = 0; g < 4; g++) k[g*4 +: 4] = 4'(segOf(p, g));
    return k;
  endfunction

  function automatic logic [15:0] payOf(int p);
    return 16'hA5C3 ^ 16'(p * 16'h1357);
  endfunction

  task automatic chk(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", what, act, exp, $time);
    end
  endtask

  task automatic loadStart(int p);
    start     = 1'b1;
    keyIn     = keyOf(p);
    payloadIn = payOf(p);
    rndIn     = 3'(offOf(p, 0));
  endtask

  task automatic runPacket(int p);
    for (int c = 0; c <= PKT_CYC; c++) begin
      @(negedge clk);
      if (c < PKT_CYC) begin
        int f = c / SLOTS;
        int s = c % SLOTS;
        int off = offOf(p, f);
        int d = segOf(p, f / 4);
        logic eRef = (s == off);
        logic eData = (s == off + d + 1);
        logic ePol = eRef ? 1'b1 : (eData ? payOf(p)[f] : 1'b0);
        chk("R3 R7 reference strobe slot", refStb, eRef);
        chk("R4 R2 data strobe slot", dataStb, eData);
        chk("R6 polarity", dataPol, ePol);
        chk("R8 done low mid-packet", done, 1'b0);
      end else begin
        chk("R8 done pulse", done, 1'b1);
        chk("R8 no ref at done", refStb, 1'b0);
        chk("R8 no data at done", dataStb, 1'b0);
      end
      // drive for the next edge
      start = 1'b0;
      if (c == 0) begin
        keyIn = ~keyOf(p);        // R2: scrambled after capture
        payloadIn = ~payOf(p);
      end
      if (c == 300) begin
        start = 1'b1;             // R9: ignored while running
        keyIn = 16'h0000;
      end
      if (c % SLOTS == SLOTS - 1 && c / SLOTS < FRAMES - 1)
        rndIn = 3'(offOf(p, c / SLOTS + 1));
      else
        rndIn = 3'((offOf(p, c / SLOTS) + 5) % 8);   // R7 misleading value
      if (c == PKT_CYC && p < NPKT - 1) loadStart(p + 1); // R10
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    rndIn = 3'd5;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 reset ref", refStb, 1'b0);
      chk("R1 reset data", dataStb, 1'b0);
      chk("R1 reset pol", dataPol, 1'b0);
      chk("R1 reset done", done, 1'b0);
    end
    rstN = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 idle ref", refStb, 1'b0);
      chk("R1 idle data", dataStb, 1'b0);
      chk("R1 idle done", done, 1'b0);
    end
    loadStart(0);
    for (int p = 0; p < NPKT; p++) runPacket(p);
    @(negedge clk);
    chk("R8 done single cycle", done, 1'b0);
    chk("R1 idle after packet ref", refStb, 1'b0);
    chk("R1 idle after packet data", dataStb, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule